// File: doc/BRIEF.md
# External Interrupt Trigger Unit

The unit takes up to six already-synchronised external interrupt pins and turns each into an interrupt request. How a pin's level becomes a request is set per pin: it can catch rising edges, falling edges or both edges in a sticky latch, or it can follow a high or low level directly. Each pin also has an enable that gates its request. Software acknowledges an edge by writing a one to that pin's clear bit.

Settings are held in 32-bit configuration words with four pin slots each. Pins 0 to 3 live in word 0 and pins 4 and 5 in word 1, at slot `pin % 4`. The word is chosen on a one-bit select. Both the write port and the read port are single-cycle.

With the default cascade build, the gated requests land in a window of the internal aggregator's status vector that starts at `CASCADE_BASE`. The dedicated CPU interrupt outputs are then held low. With `CASCADE = 0`, the requests drive the dedicated outputs instead and the status vector stays zero.

Top module: `eint_trigger_unit`

## Requirements
- R1: After reset every configuration field is 0: every pin is disabled and set to falling edge. Both configuration words read 0, and all request outputs are 0.
- R2: The field for pin slot s sits at this bit of its word: enable at s, clear at 4+s, level-select at 8+s, polarity at 12+s, both-edges at 16+s. A write updates every slot of the selected word from the next clock. Clear bits always read back 0. Slots that have no pin read 0 and ignore writes.
- R3: With level-select 0 the pin works in edge mode. Both-edges 1 catches any change of the pin. Otherwise polarity 1 catches only rising edges and polarity 0 (all three bits 0) catches only falling edges. An edge seen between two clock samples of the pin is latched at the clock edge that samples its new value.
- R4: With level-select 1 the request equals the pin when polarity is 1 (level high) and the inverted pin when polarity is 0 (level low). It follows the pin in the same cycle, ignores the both-edges bit and is never latched.
- R5: An edge latch stays set, whatever the pin does afterwards, until it is cleared. It also captures edges while the pin is disabled.
- R6: Writing 1 to a pin's clear bit empties that pin's edge latch at the write's clock edge.
- R7: If a clear and a new qualifying edge land on the same clock edge, the latch stays set.
- R8: A pin's request reaches the outputs only while its enable bit is 1. Setting the enable bit exposes an edge that was already latched.
- R9: In cascade mode pin k drives aggregator status bit `CASCADE_BASE + k`, with default base 24. All other status bits are 0 and the dedicated CPU outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | NUM_PINS | Synchronised external pin levels |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | SEL_W | Word selected for writing |
| cfg_wdata | input | REG_W | Write data |
| rd_sel | input | SEL_W | Word selected for reading |
| rd_data | output | REG_W | Read data of the selected word |
| cpu_irq_o | output | NUM_PINS | Dedicated CPU interrupt requests (non-cascade build) |
| agg_stat_o | output | STAT_W | Aggregator status bits driven by the pins (cascade build) |

## Verification
The case hardest to reach from the ports is a clear write that lands on exactly the clock edge that samples a new qualifying edge. The stimulus first clears the latch while the pin is high. It then issues the clear write in the same cycle that the pin drops, so that the clear and the falling edge meet on one clock edge. Latching while disabled needs a similar setup: an edge is made on a pin that is still disabled, and only afterwards is its enable set, so that the latched edge is exposed.

// File: rtl/eint_pkg.sv
package eint_pkg;

  // Field groups inside a configuration word; each group is SLOTS bits wide.
  typedef enum int {
    FLD_EN    = 0,
    FLD_CLR   = 1,
    FLD_LVL   = 2,
    FLD_POL   = 3,
    FLD_ANY   = 4,
    FLD_COUNT = 5
  } fld_e;

  typedef struct packed {
    logic en;
    logic lvl;
    logic pol;
    logic any;
  } pin_cfg_t;

  // Bit position of a field for a slot.
  function automatic int bitpos(fld_e fld, int slot, int slots);
    return int'(fld) * slots + slot;
  endfunction

  // Edge qualification from current and previous sampled level.
  function automatic logic edge_hit(logic cur, logic prev, logic pol, logic any);
    logic rise;
    logic fall;
    rise = cur & ~prev;
    fall = ~cur & prev;
    if (any) return rise | fall;
    return pol ? rise : fall;
  endfunction

  // Level qualification: active when pin equals the polarity bit.
  function automatic logic level_hit(logic cur, logic pol);
    return cur == pol;
  endfunction

endpackage

// File: rtl/eint_cfg_bank.sv
module eint_cfg_bank
  import eint_pkg::*;
#(
  parameter int NUM_PINS = 6,
  parameter int SLOTS    = 4,
  parameter int REG_W    = 32,
  parameter int SEL_W    = 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we_i,
  input  logic [SEL_W-1:0]          wsel_i,
  input  logic [REG_W-1:0]          wdata_i,
  input  logic [SEL_W-1:0]          rsel_i,
  output logic [REG_W-1:0]          rdata_o,
  output pin_cfg_t [NUM_PINS-1:0]   cfg_o,
  output logic [NUM_PINS-1:0]       clr_o
);

  pin_cfg_t cfg_q [NUM_PINS];

  for (genvar k = 0; k < NUM_PINS; k++) begin : g_pin
    localparam int RIX = k / SLOTS;
    localparam int SL  = k % SLOTS;
    logic hit;
    assign hit = we_i && (wsel_i == SEL_W'(RIX));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_q[k] <= '0;
      end else if (hit) begin
        cfg_q[k].en  <= wdata_i[bitpos(FLD_EN,  SL, SLOTS)];
        cfg_q[k].lvl <= wdata_i[bitpos(FLD_LVL, SL, SLOTS)];
        cfg_q[k].pol <= wdata_i[bitpos(FLD_POL, SL, SLOTS)];
        cfg_q[k].any <= wdata_i[bitpos(FLD_ANY, SL, SLOTS)];
      end
    end

    assign cfg_o[k] = cfg_q[k];
    assign clr_o[k] = hit && wdata_i[bitpos(FLD_CLR, SL, SLOTS)];
  end

  // Read mux: clear bits and absent slots stay 0.
  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < NUM_PINS; k++) begin
      if (rsel_i == SEL_W'(k / SLOTS)) begin
        rdata_o[bitpos(FLD_EN,  k % SLOTS, SLOTS)] = cfg_q[k].en;
        rdata_o[bitpos(FLD_LVL, k % SLOTS, SLOTS)] = cfg_q[k].lvl;
        rdata_o[bitpos(FLD_POL, k % SLOTS, SLOTS)] = cfg_q[k].pol;
        rdata_o[bitpos(FLD_ANY, k % SLOTS, SLOTS)] = cfg_q[k].any;
      end
    end
  end

  // Reserved write bits are deliberately dropped.
  logic unused_ok;
  assign unused_ok = ^wdata_i;

endmodule

// File: rtl/eint_pin_trig.sv
module eint_pin_trig
  import eint_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     pin_i,
  input  pin_cfg_t cfg_i,
  input  logic     clr_i,
  output logic     evt_o,
  output logic     pend_o,
  output logic     req_o
);

  logic pin_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b0;
    else        pin_q <= pin_i;
  end

  assign evt_o = !cfg_i.lvl && edge_hit(pin_i, pin_q, cfg_i.pol, cfg_i.any);

  // Sticky latch; a fresh edge outranks a clear in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pend_o <= 1'b0;
    else if (cfg_i.lvl) pend_o <= 1'b0;
    else                pend_o <= evt_o | (pend_o & ~clr_i);
  end

  assign req_o = cfg_i.lvl ? level_hit(pin_i, cfg_i.pol) : pend_o;

endmodule

// File: rtl/eint_route.sv
module eint_route #(
  parameter int NUM_PINS     = 6,
  parameter int STAT_W       = 32,
  parameter int CASCADE_BASE = 24,
  parameter bit CASCADE      = 1'b1
) (
  input  logic [NUM_PINS-1:0] req_i,
  output logic [NUM_PINS-1:0] cpu_irq_o,
  output logic [STAT_W-1:0]   agg_o
);

  // CASCADE_BASE + NUM_PINS must not exceed STAT_W.
  if (CASCADE) begin : g_cascade
    always_comb begin
      agg_o = '0;
      agg_o[CASCADE_BASE +: NUM_PINS] = req_i;
    end
    assign cpu_irq_o = '0;
  end else begin : g_direct
    assign agg_o     = '0;
    assign cpu_irq_o = req_i;
  end

endmodule

// File: rtl/eint_trigger_unit.sv
module eint_trigger_unit
  import eint_pkg::*;
#(
  parameter int NUM_PINS     = 6,
  parameter int SLOTS        = 4,
  parameter int REG_W        = 32,
  parameter int STAT_W       = 32,
  parameter int CASCADE_BASE = 24,
  parameter bit CASCADE      = 1'b1,
  localparam int NUM_REGS    = (NUM_PINS + SLOTS - 1) / SLOTS,
  localparam int SEL_W       = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic                cfg_we,
  input  logic [SEL_W-1:0]    cfg_sel,
  input  logic [REG_W-1:0]    cfg_wdata,
  input  logic [SEL_W-1:0]    rd_sel,
  output logic [REG_W-1:0]    rd_data,
  output logic [NUM_PINS-1:0] cpu_irq_o,
  output logic [STAT_W-1:0]   agg_stat_o
);

  pin_cfg_t [NUM_PINS-1:0] cfg;

  // Named internal events, brought out for the checker.
  logic [NUM_PINS-1:0] en_v;
  logic [NUM_PINS-1:0] lvl_v;
  logic [NUM_PINS-1:0] clr_v;
  logic [NUM_PINS-1:0] evt_v;
  logic [NUM_PINS-1:0] pend_v;
  logic [NUM_PINS-1:0] req_v;
  logic [NUM_PINS-1:0] out_v;

  eint_cfg_bank #(
    .NUM_PINS(NUM_PINS), .SLOTS(SLOTS), .REG_W(REG_W), .SEL_W(SEL_W)
  ) u_bank (
    .clk(clk), .rst_n(rst_n),
    .we_i(cfg_we), .wsel_i(cfg_sel), .wdata_i(cfg_wdata),
    .rsel_i(rd_sel), .rdata_o(rd_data),
    .cfg_o(cfg), .clr_o(clr_v)
  );

  for (genvar k = 0; k < NUM_PINS; k++) begin : g_trig
    eint_pin_trig u_trig (
      .clk(clk), .rst_n(rst_n),
      .pin_i(pin_i[k]), .cfg_i(cfg[k]), .clr_i(clr_v[k]),
      .evt_o(evt_v[k]), .pend_o(pend_v[k]), .req_o(req_v[k])
    );
    assign en_v[k]  = cfg[k].en;
    assign lvl_v[k] = cfg[k].lvl;
    assign out_v[k] = req_v[k] & cfg[k].en;
  end

  eint_route #(
    .NUM_PINS(NUM_PINS), .STAT_W(STAT_W),
    .CASCADE_BASE(CASCADE_BASE), .CASCADE(CASCADE)
  ) u_route (
    .req_i(out_v), .cpu_irq_o(cpu_irq_o), .agg_o(agg_stat_o)
  );

endmodule

// File: rtl/eint_trigger_chk.sv
module eint_trigger_chk #(
  parameter int NUM_PINS = 6,
  parameter int SLOTS    = 4,
  parameter int REG_W    = 32,
  parameter int STAT_W   = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_PINS-1:0] en_i,
  input logic [NUM_PINS-1:0] lvl_i,
  input logic [NUM_PINS-1:0] clr_i,
  input logic [NUM_PINS-1:0] evt_i,
  input logic [NUM_PINS-1:0] pend_i,
  input logic [NUM_PINS-1:0] out_i,
  input logic [NUM_PINS-1:0] cpu_i,
  input logic [STAT_W-1:0]   agg_i,
  input logic [REG_W-1:0]    rdata_i
);

  for (genvar k = 0; k < NUM_PINS; k++) begin : g_k
    // R5
    sticky_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_i[k] && !clr_i[k] && !lvl_i[k]) |=> (pend_i[k] || lvl_i[k]));
    // R6
    clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[k] && !evt_i[k]) |=> !pend_i[k]);
    // R7
    edge_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_i[k] |=> pend_i[k]);
    // R4
    level_never_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lvl_i[k] |=> !pend_i[k]);
    // R3
    edge_only_in_edge_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_i[k] |-> !lvl_i[k]);
    // R8
    disabled_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i[k] |-> !out_i[k]);
  end

  // R9
  route_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(agg_i) + $countones(cpu_i)) == $countones(out_i));
  // R2
  clear_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_i[SLOTS +: SLOTS] == '0);

endmodule

bind eint_trigger_unit eint_trigger_chk #(
  .NUM_PINS(NUM_PINS), .SLOTS(SLOTS), .REG_W(REG_W), .STAT_W(STAT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .en_i(en_v), .lvl_i(lvl_v), .clr_i(clr_v), .evt_i(evt_v),
  .pend_i(pend_v), .out_i(out_v), .cpu_i(cpu_irq_o),
  .agg_i(agg_stat_o), .rdata_i(rd_data)
);

// File: tb/eint_trigger_unit_test.sv
`timescale 1ns/1ps
module eint_trigger_unit_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  pin_i = '0;
  logic        cfg_we = 1'b0;
  logic [0:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic [0:0]  rd_sel = '0;
  logic [31:0] rd_data;
  logic [5:0]  cpu_irq_o;
  logic [31:0] agg_stat_o;

  always #2.5 clk = ~clk;

  eint_trigger_unit uut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .rd_sel(rd_sel), .rd_data(rd_data),
    .cpu_irq_o(cpu_irq_o), .agg_stat_o(agg_stat_o)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Scoreboard queues filled by the driver, drained by the monitor.
  string       q_tag [$];
  logic [31:0] q_agg [$];
  logic [31:0] q_rd  [$];

  task automatic drv(input logic [5:0] p, input logic we, input logic sel,
                     input logic [31:0] wd, input logic rs);
    @(posedge clk);
    #1;
    pin_i = p; cfg_we = we; cfg_sel = sel; cfg_wdata = wd; rd_sel = rs;
  endtask

  task automatic idle(input logic [5:0] p, input logic rs);
    drv(p, 1'b0, 1'b0, 32'h0, rs);
  endtask

  task automatic expect_out(input string tag, input logic [31:0] agg, input logic [31:0] rd);
    q_tag.push_back(tag);
    q_agg.push_back(agg);
    q_rd.push_back(rd);
  endtask

  always @(negedge clk) begin
    if (q_tag.size() > 0) begin
      string t;
      logic [31:0] ea;
      logic [31:0] er;
      t  = q_tag.pop_front();
      ea = q_agg.pop_front();
      er = q_rd.pop_front();
      checks++;
      if (agg_stat_o !== ea) begin
        errors++;
        $display("FAIL %s: agg_stat_o=%h expected %h", t, agg_stat_o, ea);
      end
      checks++;
      if (rd_data !== er) begin
        errors++;
        $display("FAIL %s: rd_data=%h expected %h", t, rd_data, er);
      end
      checks++;
      if (cpu_irq_o !== 6'h0) begin
        errors++;
        $display("FAIL R9 (%s): cpu_irq_o=%h expected 00", t, cpu_irq_o);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (R1..R9 unfinished): done=0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    idle(6'h00, 1'b0); expect_out("R1 reset word0", 32'h0, 32'h0);
    idle(6'h00, 1'b1); expect_out("R1 reset word1", 32'h0, 32'h0);

    // R8/R5: falling edge latched while disabled, then exposed by enable
    idle(6'h01, 1'b0); idle(6'h00, 1'b0); idle(6'h00, 1'b0);
    expect_out("R8 disabled pin hides latch", 32'h0, 32'h0);
    drv(6'h00, 1'b1, 1'b0, 32'h1, 1'b0); idle(6'h00, 1'b0);
    expect_out("R8 enable exposes latched edge", 32'h0100_0000, 32'h1);

    // R6 clear, R2 clear bit reads 0
    drv(6'h00, 1'b1, 1'b0, 32'h11, 1'b0); idle(6'h00, 1'b0);
    expect_out("R6 clear empties latch, R2 clear reads 0", 32'h0, 32'h1);

    // R5 stickiness
    idle(6'h01, 1'b0); idle(6'h00, 1'b0); idle(6'h00, 1'b0);
    expect_out("R5 falling edge latched", 32'h0100_0000, 32'h1);
    idle(6'h01, 1'b0); idle(6'h01, 1'b0); idle(6'h01, 1'b0);
    expect_out("R5 latch holds after pin returns", 32'h0100_0000, 32'h1);

    // R7 clear and edge on the same clock edge
    drv(6'h01, 1'b1, 1'b0, 32'h11, 1'b0); idle(6'h01, 1'b0);
    expect_out("R6 clear before collision", 32'h0, 32'h1);
    drv(6'h00, 1'b1, 1'b0, 32'h11, 1'b0); idle(6'h00, 1'b0);
    expect_out("R7 new edge beats clear", 32'h0100_0000, 32'h1);

    // R3 rising on pin 1
    drv(6'h00, 1'b1, 1'b0, 32'h2013, 1'b0); idle(6'h00, 1'b0);
    expect_out("R3 rising setup", 32'h0, 32'h2003);
    idle(6'h02, 1'b0); idle(6'h02, 1'b0);
    expect_out("R3 rising edge caught", 32'h0200_0000, 32'h2003);
    drv(6'h02, 1'b1, 1'b0, 32'h2023, 1'b0); idle(6'h02, 1'b0);
    expect_out("R6 clear pin1", 32'h0, 32'h2003);
    idle(6'h00, 1'b0); idle(6'h00, 1'b0);
    expect_out("R3 falling ignored in rising mode", 32'h0, 32'h2003);

    // R3 both edges on pin 2
    drv(6'h00, 1'b1, 1'b0, 32'h4_0004, 1'b0); idle(6'h00, 1'b0);
    expect_out("R3 both-edge setup", 32'h0, 32'h4_0004);
    idle(6'h04, 1'b0); idle(6'h04, 1'b0);
    expect_out("R3 both-edge rise", 32'h0400_0000, 32'h4_0004);
    drv(6'h04, 1'b1, 1'b0, 32'h4_0044, 1'b0); idle(6'h04, 1'b0);
    expect_out("R6 clear pin2", 32'h0, 32'h4_0004);
    idle(6'h00, 1'b0); idle(6'h00, 1'b0);
    expect_out("R3 both-edge fall", 32'h0400_0000, 32'h4_0004);

    // R4 level high and low on pin 3
    drv(6'h00, 1'b1, 1'b0, 32'h8808, 1'b0); idle(6'h00, 1'b0);
    expect_out("R4 level high inactive", 32'h0, 32'h8808);
    idle(6'h08, 1'b0);
    expect_out("R4 level high follows pin same cycle", 32'h0800_0000, 32'h8808);
    idle(6'h00, 1'b0);
    expect_out("R4 level request not latched", 32'h0, 32'h8808);
    drv(6'h00, 1'b1, 1'b0, 32'h0808, 1'b0); idle(6'h00, 1'b0);
    expect_out("R4 level low active", 32'h0800_0000, 32'h0808);
    idle(6'h08, 1'b0);
    expect_out("R4 level low released", 32'h0, 32'h0808);

    // R9/R2 second word: pins 4 and 5, absent slots
    drv(6'h08, 1'b1, 1'b1, 32'h303, 1'b1); idle(6'h08, 1'b1);
    expect_out("R9 pins 4,5 map to bits 28,29", 32'h3000_0000, 32'h303);
    drv(6'h08, 1'b1, 1'b1, 32'hF0F, 1'b1); idle(6'h08, 1'b1);
    expect_out("R2 absent slots read 0", 32'h3000_0000, 32'h303);

    // R3 rising through the second word on pin 4
    drv(6'h08, 1'b1, 1'b1, 32'h1001, 1'b1); idle(6'h08, 1'b1);
    expect_out("R3 pin4 rising setup", 32'h0, 32'h1001);
    idle(6'h18, 1'b1); idle(6'h18, 1'b1);
    expect_out("R3 pin4 rising edge", 32'h1000_0000, 32'h1001);

    // R4 level-select dominates both-edges
    drv(6'h18, 1'b1, 1'b0, 32'h1_1101, 1'b0); idle(6'h18, 1'b0);
    expect_out("R4 level wins over both-edges, pin low", 32'h1000_0000, 32'h1_1101);
    idle(6'h19, 1'b0);
    expect_out("R4 level wins over both-edges, pin high", 32'h1100_0000, 32'h1_1101);

    idle(6'h19, 1'b0);
    @(negedge clk); @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule